// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with 64-bit Accumulator

This block sits next to a 32-bit integer pipeline and performs the long-latency arithmetic that the main adder cannot do in one cycle. It holds a 64-bit accumulator split into a high word and a low word. It runs signed and unsigned multiplies into that pair, multiply-add and multiply-subtract against it, a multiply that only returns the low 32 bits to the pipeline, and signed and unsigned division. The pipeline can also read either word back or write either word directly.

Multiplies, including every accumulate form, take a fixed short latency. The multiplier consumes the multiplier operand a few bits per cycle and finishes with a sign and accumulate cycle. Division uses a restoring radix-2 loop. Its latency differs by one cycle between unsigned and signed operands, because a signed divide needs an extra cycle to fix the signs. While an operation is in flight, any new request is refused and `stall` stays high until the unit is free. Two mode inputs shape signed accumulation: one makes overflow saturate, and the other selects a legacy wrap-around behaviour.

Top module: `muldiv_unit`

## Requirements
- R1: A synchronous active-low reset clears the high and low words to zero and holds `busy`, `stall`, `done`, `resValid` and `overflow` low. `result` is also zero after reset.
- R2: A request is accepted on a rising edge where `opValid`=1 and `busy`=0. The `opCode` encoding is: 0 signed multiply, 1 unsigned multiply, 2 signed multiply-add, 3 unsigned multiply-add, 4 signed multiply-subtract, 5 unsigned multiply-subtract, 6 low-word multiply, 7 signed divide, 8 unsigned divide, 9 read high, 10 read low, 11 write high, 12 write low. Codes 13 to 15 are accepted but change nothing. Any code presented with `opValid`=0 also changes nothing.
- R3: Codes 0 and 1 place the full 64-bit signed or unsigned product of `opA` and `opB` into high:low. `busy` is high for 5 cycles after the accepting edge. `done` pulses for one cycle on the 5th edge, and the new value is readable from then on.
- R4: Codes 2 to 5 add the product to high:low, or subtract it, with the same 5-cycle timing. The unsigned forms wrap modulo 2^64.
- R5: Code 6 returns the low 32 bits of the signed product on `result`, with `resValid` and `done` both high on the 5th edge. The high and low words are left unchanged.
- R6: Code 8 takes 34 cycles and code 7 takes 35 cycles from the accepting edge to `done`. The low word receives the quotient truncated toward zero, and the high word receives the remainder, which carries the sign of the dividend. Dividing the most negative value by -1 gives quotient 0x80000000 and remainder 0.
- R7: A zero divisor finishes in the normal cycle count and raises no other signal. The high word receives the dividend. The low word receives 0xFFFFFFFF, except that a signed divide of a negative dividend gives 0x00000001.
- R8: Codes 11 and 12 load `opA` into the high or low word on the accepting edge, and `busy` does not rise. Codes 9 and 10 put the word on `result`, with `resValid` high in the cycle after the accepting edge. `result` holds its value otherwise.
- R9: `stall` equals `opValid` while `busy` is high. A request held through a stall is accepted on the first edge after `busy` falls, and it then sees the completed result.
- R10: With both modes at 0, a signed multiply-add or multiply-subtract whose exact result leaves the signed 64-bit range wraps and sets `overflow` when it completes. Completing any other multiply or divide clears `overflow`. Read and write requests leave it unchanged.
- R11: With `satMode`=1 and `compatMode`=0, an overflowing signed accumulate clamps high:low to 0x7FFFFFFF_FFFFFFFF or 0x80000000_00000000, following the direction of the overflow, and sets `overflow`.
- R12: With `compatMode`=1, signed accumulates always wrap and leave `overflow` at 0, whatever the value of `satMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | Request present |
| opCode | input | 4 | Operation code (see R2) |
| opA | input | 32 | First operand / dividend / word to write |
| opB | input | 32 | Second operand / divisor |
| satMode | input | 1 | Saturate signed accumulate on overflow |
| compatMode | input | 1 | Legacy wrap-around accumulate |
| stall | output | 1 | Request refused this cycle |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| resValid | output | 1 | `result` updated this cycle |
| result | output | 32 | Low-word product or read-back word |
| overflow | output | 1 | Last signed accumulate overflowed |

## Verification
The bench uses the default parameters: a 32-bit word and 8 multiplier bits per cycle. These give a 4-step multiply loop plus a finishing cycle, and a 32-step divide loop. The exact 5-, 34- and 35-cycle latencies in the requirements are therefore directly observable and are compared against a reference that only counts cycles. Operand corners such as the most negative word, all-ones inputs, zero divisors and accumulator values one step from either signed limit can be reached with 32-bit values. The randomized phase issues requests back to back, so some arrive while an operation is running and exercise the stall path.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [3:0] {
    OP_SMUL  = 4'd0,
    OP_UMUL  = 4'd1,
    OP_SMAC  = 4'd2,
    OP_UMAC  = 4'd3,
    OP_SMSB  = 4'd4,
    OP_UMSB  = 4'd5,
    OP_MULLO = 4'd6,
    OP_SDIV  = 4'd7,
    OP_UDIV  = 4'd8,
    OP_RDHI  = 4'd9,
    OP_RDLO  = 4'd10,
    OP_WRHI  = 4'd11,
    OP_WRLO  = 4'd12
  } mduOp_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic loadMul;
    logic stepMul;
    logic finMul;
    logic loadDiv;
    logic prepDiv;
    logic stepDiv;
    logic fixDiv;
    logic finDiv;
    logic writeHi;
    logic writeLo;
    logic readHi;
    logic readLo;
    logic opSigned;
    logic opAcc;
    logic opSub;
    logic opLow;
  } mduCtl_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int MUL_STEPS = 4,
  parameter int DIV_STEPS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  output mduCtl_t    ctl,
  output logic       busy,
  output logic       stall,
  output logic       done
);

  localparam int CNT_W = $clog2(DIV_STEPS + 1);
  localparam int RL_W  = $clog2(DIV_STEPS + 8) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_MUL_RUN, S_MUL_FIN, S_DIV_PREP, S_DIV_RUN, S_DIV_FIX, S_DIV_FIN
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             sgnQ, accQ, subQ, lowQ;
  logic             accept, isMul, isDiv, decSigned;
  mduOp_e           op;

  assign op        = mduOp_e'(opCode);
  assign accept    = opValid && (state == S_IDLE);
  assign isMul     = (opCode <= 4'd6);
  assign isDiv     = (op == OP_SDIV) || (op == OP_UDIV);
  assign decSigned = (op == OP_SMUL) || (op == OP_SMAC) || (op == OP_SMSB) ||
                     (op == OP_MULLO) || (op == OP_SDIV);

  assign busy  = (state != S_IDLE);
  assign stall = opValid && busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
      sgnQ  <= 1'b0;
      accQ  <= 1'b0;
      subQ  <= 1'b0;
      lowQ  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept && (isMul || isDiv)) begin
          sgnQ  <= decSigned;
          accQ  <= (opCode >= 4'd2) && (opCode <= 4'd5);
          subQ  <= (op == OP_SMSB) || (op == OP_UMSB);
          lowQ  <= (op == OP_MULLO);
          cnt   <= '0;
          state <= isMul ? S_MUL_RUN : S_DIV_PREP;
        end
        S_MUL_RUN: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(MUL_STEPS - 1)) state <= S_MUL_FIN;
        end
        S_DIV_PREP: state <= S_DIV_RUN;
        S_DIV_RUN: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(DIV_STEPS - 1)) state <= sgnQ ? S_DIV_FIX : S_DIV_FIN;
        end
        S_DIV_FIX: state <= S_DIV_FIN;
        S_MUL_FIN, S_DIV_FIN: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.loadMul  = accept && isMul;
    ctl.loadDiv  = accept && isDiv;
    ctl.writeHi  = accept && (op == OP_WRHI);
    ctl.writeLo  = accept && (op == OP_WRLO);
    ctl.readHi   = accept && (op == OP_RDHI);
    ctl.readLo   = accept && (op == OP_RDLO);
    ctl.stepMul  = (state == S_MUL_RUN);
    ctl.finMul   = (state == S_MUL_FIN);
    ctl.prepDiv  = (state == S_DIV_PREP);
    ctl.stepDiv  = (state == S_DIV_RUN);
    ctl.fixDiv   = (state == S_DIV_FIX);
    ctl.finDiv   = (state == S_DIV_FIN);
    ctl.opSigned = accept ? decSigned : sgnQ;
    ctl.opAcc    = accQ;
    ctl.opSub    = subQ;
    ctl.opLow    = lowQ;
  end

  // checker: edges since the accepting edge
  logic [RL_W-1:0] runLen;
  always_ff @(posedge clk) begin
    if (!rstN)       runLen <= '0;
    else if (accept) runLen <= '0;
    else if (busy)   runLen <= runLen + RL_W'(1);
  end

  // R3 and R6: completion only at the fixed latencies
  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runLen == RL_W'(MUL_STEPS + 1)) || (runLen == RL_W'(DIV_STEPS + 2)) ||
             (runLen == RL_W'(DIV_STEPS + 3)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !stall);

  p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(opValid));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/mdu_dp.sv
module mdu_dp
  import mdu_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int STEP_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  mduCtl_t          ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             satMode,
  input  logic             compatMode,
  output logic [WIDTH-1:0] result,
  output logic             resValid,
  output logic             overflow
);

  localparam int DW = 2 * WIDTH;
  localparam logic [DW-1:0] SAT_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SAT_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [WIDTH-1:0] hiReg, loReg;
  logic [DW-1:0]    mcand, prod;
  logic [WIDTH-1:0] mplier;
  logic             negRes;
  logic [WIDTH-1:0] quo, rem, divisor;
  logic             negQ, negR;

  function automatic logic [WIDTH-1:0] absv(input logic [WIDTH-1:0] v, input logic s);
    return (s && v[WIDTH-1]) ? -v : v;
  endfunction

  // finishing-cycle arithmetic
  logic [DW-1:0] signedProd, addend, accIn, res64;
  logic [DW:0]   sum;
  logic          ovfRaw;
  logic [WIDTH+1:0] trial;

  always_comb begin
    signedProd = negRes ? -prod : prod;
    accIn      = {hiReg, loReg};
    addend     = ctl.opSub ? -signedProd : signedProd;
    sum        = {accIn[DW-1], accIn} + {addend[DW-1], addend};
    ovfRaw     = ctl.opAcc && ctl.opSigned && !compatMode && (sum[DW] ^ sum[DW-1]);
    if (!ctl.opAcc)             res64 = signedProd;
    else if (ovfRaw && satMode) res64 = sum[DW] ? SAT_MIN : SAT_MAX;
    else                        res64 = sum[DW-1:0];
    trial = {1'b0, rem, quo[WIDTH-1]} - {2'b00, divisor};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0; loReg <= '0; result <= '0; resValid <= 1'b0; overflow <= 1'b0;
      mcand <= '0; prod <= '0; mplier <= '0; negRes <= 1'b0;
      quo <= '0; rem <= '0; divisor <= '0; negQ <= 1'b0; negR <= 1'b0;
    end else begin
      resValid <= 1'b0;
      if (ctl.writeHi) hiReg <= opA;
      if (ctl.writeLo) loReg <= opA;
      if (ctl.readHi) begin result <= hiReg; resValid <= 1'b1; end
      if (ctl.readLo) begin result <= loReg; resValid <= 1'b1; end
      if (ctl.loadMul) begin
        mcand  <= {{WIDTH{1'b0}}, absv(opA, ctl.opSigned)};
        mplier <= absv(opB, ctl.opSigned);
        prod   <= '0;
        negRes <= ctl.opSigned && (opA[WIDTH-1] ^ opB[WIDTH-1]);
      end
      if (ctl.stepMul) begin
        prod   <= prod + mcand * {{(DW-STEP_BITS){1'b0}}, mplier[STEP_BITS-1:0]};
        mcand  <= mcand << STEP_BITS;
        mplier <= mplier >> STEP_BITS;
      end
      if (ctl.finMul) begin
        overflow <= ovfRaw;
        if (ctl.opLow) begin
          result   <= signedProd[WIDTH-1:0];
          resValid <= 1'b1;
        end else begin
          {hiReg, loReg} <= res64;
        end
      end
      if (ctl.loadDiv) begin
        quo     <= opA;
        divisor <= opB;
      end
      if (ctl.prepDiv) begin
        quo     <= absv(quo, ctl.opSigned);
        divisor <= absv(divisor, ctl.opSigned);
        rem     <= '0;
        negQ    <= ctl.opSigned && (quo[WIDTH-1] ^ divisor[WIDTH-1]);
        negR    <= ctl.opSigned && quo[WIDTH-1];
      end
      if (ctl.stepDiv) begin
        if (!trial[WIDTH+1]) begin
          rem <= trial[WIDTH-1:0];
          quo <= {quo[WIDTH-2:0], 1'b1};
        end else begin
          rem <= {rem[WIDTH-2:0], quo[WIDTH-1]};
          quo <= {quo[WIDTH-2:0], 1'b0};
        end
      end
      if (ctl.fixDiv) begin
        if (negQ) quo <= -quo;
        if (negR) rem <= -rem;
      end
      if (ctl.finDiv) begin
        loReg    <= quo;
        hiReg    <= rem;
        overflow <= 1'b0;
      end
    end
  end

  // R6: restoring invariant, partial remainder below the divisor
  p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepDiv && (divisor != '0) |=> (rem < divisor));

  p_hilo_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finMul && ctl.opLow |=> $stable({hiReg, loReg}) && resValid);

  p_sat_clamp_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finMul && ovfRaw && satMode |=>
      overflow && (({hiReg, loReg} == SAT_MAX) || ({hiReg, loReg} == SAT_MIN)));

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finMul && compatMode |=> !overflow);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int WIDTH         = 32,
  parameter int MUL_STEP_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [3:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             satMode,
  input  logic             compatMode,
  output logic             stall,
  output logic             busy,
  output logic             done,
  output logic             resValid,
  output logic [WIDTH-1:0] result,
  output logic             overflow
);

  localparam int MUL_STEPS = WIDTH / MUL_STEP_BITS;
  localparam int DIV_STEPS = WIDTH;

  mduCtl_t ctl;

  mdu_ctrl #(.MUL_STEPS(MUL_STEPS), .DIV_STEPS(DIV_STEPS)) ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .ctl(ctl), .busy(busy), .stall(stall), .done(done)
  );

  mdu_dp #(.WIDTH(WIDTH), .STEP_BITS(MUL_STEP_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(opA), .opB(opB),
    .satMode(satMode), .compatMode(compatMode),
    .result(result), .resValid(resValid), .overflow(overflow)
  );

endmodule

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [31:0] opA = '0, opB = '0;
  logic        satMode = 1'b0, compatMode = 1'b0;
  logic        stall, busy, done, resValid, overflow;
  logic [31:0] result;

  always #2 clk = ~clk;

  muldiv_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opA(opA), .opB(opB),
    .satMode(satMode), .compatMode(compatMode), .stall(stall), .busy(busy),
    .done(done), .resValid(resValid), .result(result), .overflow(overflow)
  );

  int    nTests = 0, nFail = 0, cycles = 0;
  string curReq = "R1";
  bit    armed = 0, acceptedLast = 0;

  // behavioural reference
  logic [31:0] mHi, mLo, mResult, pHi, pLo, pRes;
  logic        mDone, mResValid, mOvf, pOvf, pLow;
  int          mRem = 0;

  localparam logic signed [65:0] SMAX = 66'sh07FFFFFFFFFFFFFFF;
  localparam logic signed [65:0] SMIN = -SMAX - 66'sd1;

  task automatic modelAccept(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0]        acc, up, r64;
    longint             sa, sb, sp, q, r;
    logic signed [65:0] ex;
    logic               ov;
    acc = {mHi, mLo};
    sa = longint'($signed(a)); sb = longint'($signed(b));
    sp = sa * sb;
    up = {32'b0, a} * {32'b0, b};
    pLow = 0; pOvf = 0; pHi = mHi; pLo = mLo;
    case (op)
      4'd0: begin {pHi, pLo} = sp; mRem = 5; end
      4'd1: begin {pHi, pLo} = up; mRem = 5; end
      4'd2, 4'd4: begin
        ex = (op == 4'd4) ? ($signed({{2{acc[63]}}, acc}) - $signed({{2{sp[63]}}, sp}))
                          : ($signed({{2{acc[63]}}, acc}) + $signed({{2{sp[63]}}, sp}));
        ov = (ex > SMAX) || (ex < SMIN);
        r64 = ex[63:0];
        if (compatMode) ov = 0;
        else if (ov && satMode) r64 = (ex < 0) ? 64'h8000000000000000 : 64'h7FFFFFFFFFFFFFFF;
        {pHi, pLo} = r64; pOvf = ov; mRem = 5;
      end
      4'd3: begin {pHi, pLo} = acc + up; mRem = 5; end
      4'd5: begin {pHi, pLo} = acc - up; mRem = 5; end
      4'd6: begin pRes = sp[31:0]; pLow = 1; mRem = 5; end
      4'd7: begin
        if (b == 0) begin pLo = a[31] ? 32'd1 : 32'hFFFFFFFF; pHi = a; end
        else begin q = sa / sb; r = sa % sb; pLo = q[31:0]; pHi = r[31:0]; end
        mRem = 35;
      end
      4'd8: begin
        if (b == 0) begin pLo = 32'hFFFFFFFF; pHi = a; end
        else begin pLo = a / b; pHi = a % b; end
        mRem = 34;
      end
      4'd9:  begin mResult = mHi; mResValid = 1; end
      4'd10: begin mResult = mLo; mResValid = 1; end
      4'd11: mHi = a;
      4'd12: mLo = a;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    armed <= 1;
    if (!rstN) begin
      mHi = 0; mLo = 0; mResult = 0; mDone = 0; mResValid = 0; mOvf = 0; mRem = 0;
      acceptedLast = 0;
    end else begin
      mDone = 0; mResValid = 0; acceptedLast = 0;
      if (mRem > 0) begin
        mRem--;
        if (mRem == 0) begin
          mDone = 1; mOvf = pOvf;
          if (pLow) begin mResult = pRes; mResValid = 1; end
          else begin mHi = pHi; mLo = pLo; end
        end
      end else if (opValid) begin
        acceptedLast = 1;
        modelAccept(opCode, opA, opB);
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) if (armed) begin
    nTests++;
    if (busy !== (mRem > 0) || stall !== (opValid && mRem > 0) || done !== mDone ||
        resValid !== mResValid || result !== mResult || overflow !== mOvf) begin
      nFail++;
      $display("FAIL %s cycle %0d: busy/stall/done/rv/res/ovf actual %0b%0b%0b%0b %h %0b expected %0b%0b%0b%0b %h %0b",
               curReq, cycles, busy, stall, done, resValid, result, overflow,
               (mRem > 0), (opValid && mRem > 0), mDone, mResValid, mResult, mOvf);
    end
  end

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); #1;
    opValid = 1; opCode = op; opA = a; opB = b;
    do @(negedge clk); while (!acceptedLast);
    #1 opValid = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic readWord(input logic hi, input logic [31:0] exp, input string tag);
    waitIdle();
    issue(hi ? 4'd9 : 4'd10, 32'd0, 32'd0);
    checkVal(tag, result, exp);
  endtask

  task automatic timedOp(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input int lat, input string tag);
    int n = 0;
    waitIdle();
    issue(op, a, b);
    while (!done && n < 100) begin @(negedge clk); n++; end
    checkVal(tag, n, lat);
  endtask

  task automatic setHiLo(input logic [31:0] h, input logic [31:0] l);
    waitIdle();
    issue(4'd11, h, 0);
    issue(4'd12, l, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    curReq = "R1";
    readWord(1, 32'h0, "R1 hi after reset");
    readWord(0, 32'h0, "R1 lo after reset");

    curReq = "R8";
    setHiLo(32'h12345678, 32'h9ABCDEF0);
    readWord(1, 32'h12345678, "R8 hi write/read");
    readWord(0, 32'h9ABCDEF0, "R8 lo write/read");

    curReq = "R2";
    @(negedge clk); #1 opCode = 4'd11; opA = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    issue(4'd13, 32'h1, 32'h1);
    issue(4'd15, 32'h1, 32'h1);
    readWord(1, 32'h12345678, "R2 idle/unused codes ignored");

    curReq = "R3";
    timedOp(4'd0, 32'hFFFFFFFD, 32'd7, 5, "R3 signed mul latency");
    readWord(1, 32'hFFFFFFFF, "R3 signed mul hi");
    readWord(0, 32'hFFFFFFEB, "R3 signed mul lo");
    timedOp(4'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 5, "R3 unsigned mul latency");
    readWord(1, 32'hFFFFFFFE, "R3 unsigned max hi");
    readWord(0, 32'h00000001, "R3 unsigned max lo");
    timedOp(4'd0, 32'h80000000, 32'h80000000, 5, "R3 min*min latency");
    readWord(1, 32'h40000000, "R3 min*min hi");

    curReq = "R4";
    setHiLo(0, 32'h10);
    timedOp(4'd2, 32'd2, 32'd3, 5, "R4 madd latency");
    readWord(0, 32'h16, "R4 madd");
    issue(4'd4, 32'd4, 32'd5);
    readWord(0, 32'h2, "R4 msub");
    issue(4'd5, 32'd1, 32'd3);
    readWord(1, 32'hFFFFFFFF, "R4 msubu wrap hi");
    issue(4'd3, 32'd1, 32'd1);
    readWord(1, 32'h0, "R4 maddu wrap hi");

    curReq = "R5";
    setHiLo(32'hAAAAAAAA, 32'h55555555);
    timedOp(4'd6, 32'hFFFFFFFE, 32'd3, 5, "R5 low mul latency");
    checkVal("R5 low mul result", result, 32'hFFFFFFFA);
    readWord(1, 32'hAAAAAAAA, "R5 hi kept");

    curReq = "R6";
    timedOp(4'd8, 32'd100, 32'd7, 34, "R6 unsigned div latency");
    readWord(0, 32'd14, "R6 udiv quotient");
    readWord(1, 32'd2, "R6 udiv remainder");
    timedOp(4'd7, 32'hFFFFFFF9, 32'd2, 35, "R6 signed div latency");
    readWord(0, 32'hFFFFFFFD, "R6 sdiv quotient");
    readWord(1, 32'hFFFFFFFF, "R6 sdiv remainder sign");
    issue(4'd7, 32'd7, 32'hFFFFFFFE);
    readWord(1, 32'd1, "R6 sdiv positive dividend rem");
    issue(4'd7, 32'h80000000, 32'hFFFFFFFF);
    readWord(0, 32'h80000000, "R6 min/-1 quotient");
    readWord(1, 32'h0, "R6 min/-1 remainder");

    curReq = "R7";
    timedOp(4'd8, 32'd5, 32'd0, 34, "R7 udiv by zero latency");
    readWord(0, 32'hFFFFFFFF, "R7 udiv by zero lo");
    readWord(1, 32'd5, "R7 udiv by zero hi");
    timedOp(4'd7, 32'hFFFFFFFB, 32'd0, 35, "R7 sdiv by zero latency");
    readWord(0, 32'h1, "R7 sdiv by zero lo");

    curReq = "R9";
    waitIdle();
    issue(4'd0, 32'd6, 32'd7);
    issue(4'd10, 0, 0);
    checkVal("R9 stalled read sees product", result, 32'h2A);

    curReq = "R10";
    setHiLo(32'h7FFFFFFF, 32'hFFFFFFFF);
    issue(4'd2, 32'd1, 32'd1); waitIdle();
    checkVal("R10 overflow flag", {31'b0, overflow}, 1);
    readWord(1, 32'h80000000, "R10 wrap hi");
    issue(4'd0, 32'd1, 32'd1); waitIdle();
    checkVal("R10 flag cleared", {31'b0, overflow}, 0);

    curReq = "R11";
    satMode = 1;
    setHiLo(32'h7FFFFFFF, 32'hFFFFFFFF);
    issue(4'd2, 32'd1, 32'd1); waitIdle();
    checkVal("R11 overflow flag", {31'b0, overflow}, 1);
    readWord(1, 32'h7FFFFFFF, "R11 clamp max hi");
    readWord(0, 32'hFFFFFFFF, "R11 clamp max lo");
    setHiLo(32'h80000000, 32'h0);
    issue(4'd4, 32'd1, 32'd1);
    readWord(1, 32'h80000000, "R11 clamp min hi");
    readWord(0, 32'h0, "R11 clamp min lo");

    curReq = "R12";
    compatMode = 1;
    setHiLo(32'h7FFFFFFF, 32'hFFFFFFFF);
    issue(4'd2, 32'd1, 32'd1); waitIdle();
    checkVal("R12 no overflow flag", {31'b0, overflow}, 0);
    readWord(1, 32'h80000000, "R12 wraps");
    compatMode = 0; satMode = 0;

    curReq = "R9 random";
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) begin
        waitIdle();
        satMode = $urandom_range(0, 1);
        compatMode = $urandom_range(0, 3) == 0;
      end
      issue(4'($urandom_range(0, 15)),
            ($urandom_range(0, 3) == 0) ? 32'h80000000 : $urandom,
            ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom);
    end
    waitIdle();
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule